// File: doc/BRIEF.md
# Operand Wakeup Scoreboard

This block keeps one ready bit per physical register for an issue queue and tells each queue slot when both of its source operands are available. When an instruction is dispatched into a slot, the block records the slot's source tags and sequence number. Each source starts out ready or pending. It is ready if the front end already marked it ready, if the scoreboard shows its register as written, if the tag lies outside the tracked register range, or if a completion for that tag arrives in the same cycle. Dispatch also clears the scoreboard bit of the destination register, because a new producer now owns it.

A completion port announces one finished destination tag per cycle. It sets that register's scoreboard bit and wakes every valid slot whose pending source carries the tag. A squash port removes every slot holding an instruction younger than a given sequence number, so their pending wakeups die with them. Each slot drives a ready-to-issue flag, and the scoreboard contents are visible as an output vector.

Top module: `opnd_wakeup_sb`

## Requirements
- R1: After reset every scoreboard bit is 0 (not ready) and every slot is invalid, so no ready flag is set.
- R2: A dispatched source whose front-end ready bit (`disp_src_rdy[s]`) is 1 counts as ready whatever the scoreboard holds. Source slot s uses bits `[s*TAG_W +: TAG_W]` of `disp_src_tag`.
- R3: A dispatched source not marked ready by the front end takes the scoreboard bit of its tag. If that bit is 1 the source is ready. If it is 0 the slot waits for a completion of that tag.
- R4: An accepted dispatch with `disp_dst_valid` clears the scoreboard bit of `disp_dst_tag` from the next cycle. When a completion names the same tag in the same cycle, the clear wins.
- R5: A tag greater than or equal to NUM_PREGS is never tracked. As a source it counts as ready. As a destination or as a completion it leaves the scoreboard unchanged.
- R6: A completion of an in-range tag sets its scoreboard bit and marks every matching pending source of every valid slot ready. Both effects appear on the outputs in the following cycle.
- R7: A slot's ready flag is 1 only while the slot is valid and both of its sources are ready.
- R8: A source whose tag is completed in the same cycle as its dispatch is recorded as ready.
- R9: A squash invalidates every valid slot whose sequence number is strictly greater than `sq_seq` and keeps the others. A later completion does not revive a removed slot.
- R10: A dispatch in a squash cycle whose `disp_seq` is greater than `sq_seq` is discarded entirely, including its destination clear. An older or equal one is accepted.
- R11: A dispatch to an occupied slot replaces that slot's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_idx | input | $clog2(ENTRIES) | Slot being written |
| disp_seq | input | SEQ_W | Sequence number of the dispatched instruction |
| disp_src_tag | input | 2*TAG_W | Source register tags, slot s at [s*TAG_W +: TAG_W] |
| disp_src_rdy | input | 2 | Front-end ready bit per source |
| disp_dst_valid | input | 1 | Instruction writes a destination register |
| disp_dst_tag | input | TAG_W | Destination register tag |
| cmpl_valid | input | 1 | Completion broadcast |
| cmpl_tag | input | TAG_W | Completed destination tag |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash point; strictly younger slots are removed |
| ent_valid | output | ENTRIES | Slot occupied |
| ent_ready | output | ENTRIES | Slot ready to issue |
| sb_state | output | NUM_PREGS | Scoreboard ready bits |

## Verification
Two collisions get the most attention. The first is a completion and a dispatch naming the same tag in one cycle. The bench sweeps every tag, including out-of-range tags, against every mix of front-end ready bit, prior scoreboard state and same-cycle completion, and checks the slot's ready flag against an arithmetic OR of those terms. The same pairing on the destination side must leave the scoreboard bit cleared. The second collision is a squash meeting a dispatch: the bench issues younger and older dispatches in squash cycles and compares slot occupancy with a cycle model, then runs long random traffic that mixes all three ports.

// File: rtl/owu_pkg.sv
`timescale 1ns/1ps
package owu_pkg;
   // every slot carries exactly this many source operands
   localparam int NUM_SRC = 2;

   // strict age comparison on zero-extended sequence numbers
   function automatic logic is_younger(input logic [31:0] cand, input logic [31:0] point);
      return cand > point;
   endfunction
endpackage

// File: rtl/owu_scoreboard.sv
`timescale 1ns/1ps
module owu_scoreboard #(
   parameter int NUM_PREGS = 64,
   parameter int TAG_W     = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_v,
   input  logic [TAG_W-1:0]     set_tag,
   input  logic                 clr_v,
   input  logic [TAG_W-1:0]     clr_tag,
   output logic [NUM_PREGS-1:0] bits_o
);
   logic [NUM_PREGS-1:0] bits_q;
   logic [NUM_PREGS-1:0] set_oh, clr_oh;

   assign set_oh = NUM_PREGS'(1) << set_tag;
   assign clr_oh = NUM_PREGS'(1) << clr_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else begin
         for (int p = 0; p < NUM_PREGS; p++) begin
            if (clr_v && clr_tag == TAG_W'(p))
               bits_q[p] <= 1'b0;
            else if (set_v && set_tag == TAG_W'(p))
               bits_q[p] <= 1'b1;
         end
      end
   end

   assign bits_o = bits_q;

   // R4
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_v |=> ((bits_o & $past(clr_oh)) == '0));

   // R6
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v && !(clr_v && clr_tag == set_tag)) |=> ((bits_o & $past(set_oh)) == $past(set_oh)));
endmodule

// File: rtl/owu_entry.sv
`timescale 1ns/1ps
module owu_entry
   import owu_pkg::*;
#(
   parameter int TAG_W = 7,
   parameter int SEQ_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SEQ_W-1:0]         wr_seq,
   input  logic [NUM_SRC*TAG_W-1:0] wr_tags,
   input  logic [NUM_SRC-1:0]       wr_rdy,
   input  logic                     cmpl_v,
   input  logic [TAG_W-1:0]         cmpl_tag,
   input  logic                     kill,
   output logic                     valid_o,
   output logic                     ready_o,
   output logic [SEQ_W-1:0]         seq_o
);
   logic               valid_q;
   logic [SEQ_W-1:0]   seq_q;
   logic [TAG_W-1:0]   tag_q [NUM_SRC];
   logic [NUM_SRC-1:0] rdy_q;
   logic [NUM_SRC-1:0] hit;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
      assign hit[s] = cmpl_v && (tag_q[s] == cmpl_tag);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         seq_q   <= '0;
         rdy_q   <= '0;
         for (int s = 0; s < NUM_SRC; s++) tag_q[s] <= '0;
      end else if (wr_en) begin
         valid_q <= 1'b1;
         seq_q   <= wr_seq;
         rdy_q   <= wr_rdy;
         for (int s = 0; s < NUM_SRC; s++) tag_q[s] <= wr_tags[s*TAG_W +: TAG_W];
      end else if (kill) begin
         valid_q <= 1'b0;
      end else if (valid_q) begin
         rdy_q <= rdy_q | hit;
      end
   end

   assign valid_o = valid_q;
   assign seq_o   = seq_q;
   assign ready_o = valid_q && (&rdy_q);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
      // R6
      wake_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (valid_q && !wr_en && !kill && hit[s]) |=> rdy_q[s]);
   end

   // R9
   kill_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && !wr_en) |=> !valid_o);

   // R7
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !wr_en && !kill) |=> ready_o);
endmodule

// File: rtl/opnd_wakeup_sb.sv
`timescale 1ns/1ps
module opnd_wakeup_sb
   import owu_pkg::*;
#(
   parameter int NUM_PREGS = 64,
   parameter int TAG_W     = 7,
   parameter int ENTRIES   = 16,
   parameter int SEQ_W     = 8,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     disp_valid,
   input  logic [IDX_W-1:0]         disp_idx,
   input  logic [SEQ_W-1:0]         disp_seq,
   input  logic [NUM_SRC*TAG_W-1:0] disp_src_tag,
   input  logic [NUM_SRC-1:0]       disp_src_rdy,
   input  logic                     disp_dst_valid,
   input  logic [TAG_W-1:0]         disp_dst_tag,
   input  logic                     cmpl_valid,
   input  logic [TAG_W-1:0]         cmpl_tag,
   input  logic                     sq_valid,
   input  logic [SEQ_W-1:0]         sq_seq,
   output logic [ENTRIES-1:0]       ent_valid,
   output logic [ENTRIES-1:0]       ent_ready,
   output logic [NUM_PREGS-1:0]     sb_state
);
   localparam bit FULL_RANGE = (NUM_PREGS == (1 << TAG_W));

   if (ENTRIES < 2)                 begin : g_bad_ent  $error("ENTRIES must be at least 2"); end
   if (NUM_PREGS < 2)               begin : g_bad_preg $error("NUM_PREGS must be at least 2"); end
   if (NUM_PREGS > (1 << TAG_W))    begin : g_bad_tag  $error("TAG_W too narrow for NUM_PREGS"); end
   if (SEQ_W < 1 || SEQ_W > 32)     begin : g_bad_seq  $error("SEQ_W out of range"); end

   logic [NUM_SRC-1:0] src_in;
   logic               dst_in, cmpl_in;
   logic [TAG_W-1:0]   src_tag [NUM_SRC];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src_tag
      assign src_tag[s] = disp_src_tag[s*TAG_W +: TAG_W];
   end

   // range test: nothing to compare when the tag space is fully populated
   if (FULL_RANGE) begin : g_full
      assign src_in  = '1;
      assign dst_in  = 1'b1;
      assign cmpl_in = 1'b1;
   end else begin : g_part
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
         assign src_in[s] = src_tag[s] < TAG_W'(NUM_PREGS);
      end
      assign dst_in  = disp_dst_tag < TAG_W'(NUM_PREGS);
      assign cmpl_in = cmpl_tag < TAG_W'(NUM_PREGS);
   end

   function automatic logic sb_lookup(input logic [NUM_PREGS-1:0] b, input logic [TAG_W-1:0] t);
      logic r;
      r = 1'b0;
      for (int p = 0; p < NUM_PREGS; p++)
         if (t == TAG_W'(p)) r = b[p];
      return r;
   endfunction

   logic                 cmpl_trk;
   logic                 disp_drop, disp_acc;
   logic                 clr_v;
   logic [NUM_SRC-1:0]   src_rdy_now;
   logic [NUM_PREGS-1:0] sb_bits;

   assign cmpl_trk  = cmpl_valid && cmpl_in;
   assign disp_drop = sq_valid && is_younger(32'(disp_seq), 32'(sq_seq));
   assign disp_acc  = disp_valid && !disp_drop;
   assign clr_v     = disp_acc && disp_dst_valid && dst_in;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_lookup
      assign src_rdy_now[s] = disp_src_rdy[s]
                            || !src_in[s]
                            || sb_lookup(sb_bits, src_tag[s])
                            || (cmpl_trk && cmpl_tag == src_tag[s]);
   end

   owu_scoreboard #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_sb (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_v   (cmpl_trk),
      .set_tag (cmpl_tag),
      .clr_v   (clr_v),
      .clr_tag (disp_dst_tag),
      .bits_o  (sb_bits)
   );

   logic [SEQ_W-1:0] ent_seq [ENTRIES];
   logic [ENTRIES-1:0] wr_en, kill;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      assign wr_en[e] = disp_acc && (disp_idx == IDX_W'(e));
      assign kill[e]  = sq_valid && ent_valid[e] && is_younger(32'(ent_seq[e]), 32'(sq_seq));

      owu_entry #(.TAG_W(TAG_W), .SEQ_W(SEQ_W)) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en[e]),
         .wr_seq   (disp_seq),
         .wr_tags  (disp_src_tag),
         .wr_rdy   (src_rdy_now),
         .cmpl_v   (cmpl_trk),
         .cmpl_tag (cmpl_tag),
         .kill     (kill[e]),
         .valid_o  (ent_valid[e]),
         .ready_o  (ent_ready[e]),
         .seq_o    (ent_seq[e])
      );

      // R9
      no_young_survivor_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sq_valid && !wr_en[e]) |=> !(ent_valid[e] && (ent_seq[e] > $past(sq_seq))));
   end

   assign sb_state = sb_bits;

   // R5
   untracked_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmpl_valid && !cmpl_in && !clr_v) |=> $stable(sb_state));

   // R10
   dropped_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_drop && !cmpl_valid) |=> $stable(sb_state));
endmodule

// File: tb/opnd_wakeup_sb_test.sv
`timescale 1ns/1ps
module opnd_wakeup_sb_test;
   localparam int NP = 8;
   localparam int TW = 4;
   localparam int NE = 4;
   localparam int SW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          disp_valid = 0;
   logic [1:0]    disp_idx = 0;
   logic [SW-1:0] disp_seq = 0;
   logic [2*TW-1:0] disp_src_tag = 0;
   logic [1:0]    disp_src_rdy = 0;
   logic          disp_dst_valid = 0;
   logic [TW-1:0] disp_dst_tag = 0;
   logic          cmpl_valid = 0;
   logic [TW-1:0] cmpl_tag = 0;
   logic          sq_valid = 0;
   logic [SW-1:0] sq_seq = 0;
   logic [NE-1:0] ent_valid, ent_ready;
   logic [NP-1:0] sb_state;

   opnd_wakeup_sb #(.NUM_PREGS(NP), .TAG_W(TW), .ENTRIES(NE), .SEQ_W(SW)) uut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_idx(disp_idx), .disp_seq(disp_seq),
      .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy),
      .disp_dst_valid(disp_dst_valid), .disp_dst_tag(disp_dst_tag),
      .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
      .sq_valid(sq_valid), .sq_seq(sq_seq),
      .ent_valid(ent_valid), .ent_ready(ent_ready), .sb_state(sb_state)
   );

   int n_checks = 0;
   int n_err = 0;
   bit finished = 0;

   // reference model
   logic          m_sb  [NP];
   logic          m_v   [NE];
   logic [SW-1:0] m_seq [NE];
   logic [TW-1:0] m_tag [NE][2];
   logic          m_rdy [NE][2];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic hit(input logic [TW-1:0] t);
      return cmpl_valid && cmpl_tag == t && t < NP;
   endfunction

   task automatic model_reset();
      for (int p = 0; p < NP; p++) m_sb[p] = 0;
      for (int e = 0; e < NE; e++) begin
         m_v[e] = 0; m_seq[e] = 0;
         for (int s = 0; s < 2; s++) begin m_tag[e][s] = 0; m_rdy[e][s] = 0; end
      end
   endtask

   // advance one clock: model next state from current inputs, then compare
   task automatic cyc();
      logic n_sb [NP];
      logic n_v [NE];
      logic n_rdy [NE][2];
      logic acc;
      logic [NP-1:0] e_sb;
      logic [NE-1:0] e_v, e_r;
      acc = disp_valid && !(sq_valid && disp_seq > sq_seq);
      for (int p = 0; p < NP; p++) begin
         n_sb[p] = m_sb[p];
         if (acc && disp_dst_valid && disp_dst_tag == p) n_sb[p] = 0;
         else if (cmpl_valid && cmpl_tag == p) n_sb[p] = 1;
      end
      for (int e = 0; e < NE; e++) begin
         n_v[e] = m_v[e];
         for (int s = 0; s < 2; s++) n_rdy[e][s] = m_rdy[e][s];
         if (acc && disp_idx == e) begin
            n_v[e] = 1;
            m_seq[e] = disp_seq;
            for (int s = 0; s < 2; s++) begin
               logic [TW-1:0] t;
               t = disp_src_tag[s*TW +: TW];
               m_tag[e][s] = t;
               n_rdy[e][s] = disp_src_rdy[s] || (t >= NP) || ((t < NP) && m_sb[t[2:0]]) || hit(t);
            end
         end else if (sq_valid && m_v[e] && m_seq[e] > sq_seq) begin
            n_v[e] = 0;
         end else if (m_v[e]) begin
            for (int s = 0; s < 2; s++) n_rdy[e][s] = m_rdy[e][s] || hit(m_tag[e][s]);
         end
      end
      @(posedge clk);
      #1;
      for (int p = 0; p < NP; p++) m_sb[p] = n_sb[p];
      for (int e = 0; e < NE; e++) begin
         m_v[e] = n_v[e];
         for (int s = 0; s < 2; s++) m_rdy[e][s] = n_rdy[e][s];
      end
      for (int p = 0; p < NP; p++) e_sb[p] = m_sb[p];
      for (int e = 0; e < NE; e++) begin
         e_v[e] = m_v[e];
         e_r[e] = m_v[e] && m_rdy[e][0] && m_rdy[e][1];
      end
      check("R6 scoreboard", 32'(sb_state), 32'(e_sb));
      check("R9 occupancy", 32'(ent_valid), 32'(e_v));
      check("R7 ready", 32'(ent_ready), 32'(e_r));
      disp_valid = 0; cmpl_valid = 0; sq_valid = 0;
   endtask

   task automatic dispatch(input int idx, input int seq, input int t0, input bit r0,
                           input int t1, input bit r1, input bit dv, input int dt);
      disp_valid = 1; disp_idx = 2'(idx); disp_seq = SW'(seq);
      disp_src_tag = {TW'(t1), TW'(t0)}; disp_src_rdy = {r1, r0};
      disp_dst_valid = dv; disp_dst_tag = TW'(dt);
   endtask

   task automatic complete(input int t);
      cmpl_valid = 1; cmpl_tag = TW'(t);
   endtask

   task automatic squash(input int s);
      sq_valid = 1; sq_seq = SW'(s);
   endtask

   initial begin : watchdog
      #500000;
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_checks);
         $finish;
      end
   end

   initial begin : main
      logic [NP-1:0] saved;
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1
      check("R1 scoreboard", 32'(sb_state), 0);
      check("R1 valid", 32'(ent_valid), 0);
      check("R1 ready", 32'(ent_ready), 0);

      // R2: front-end ready bits bypass scoreboard
      dispatch(0, 1, 1, 1, 2, 1, 0, 0); cyc();
      check("R2", 32'(ent_ready[0]), 1);
      // R3: scoreboard clear -> waits
      dispatch(1, 2, 3, 0, 0, 1, 0, 0); cyc();
      check("R3 pending", 32'(ent_ready[1]), 0);
      complete(5); cyc();
      check("R6 sb set", 32'(sb_state[5]), 1);
      dispatch(2, 3, 5, 0, 0, 1, 0, 0); cyc();
      check("R3 scoreboard hit", 32'(ent_ready[2]), 1);
      // R6: completion wakes slot 1
      complete(3); cyc();
      check("R6 wake", 32'(ent_ready[1]), 1);
      check("R6 sb", 32'(sb_state[3]), 1);
      // R4: destination clear, and clear beats same-cycle completion
      dispatch(3, 4, 0, 1, 0, 1, 1, 3); cyc();
      check("R4 clear", 32'(sb_state[3]), 0);
      complete(3); cyc();
      dispatch(3, 4, 0, 1, 0, 1, 1, 3); complete(3); cyc();
      check("R4 clear wins", 32'(sb_state[3]), 0);
      // R5: out-of-range tags
      saved = sb_state;
      dispatch(0, 6, 9, 0, 12, 0, 1, 10); cyc();
      check("R5 src", 32'(ent_ready[0]), 1);
      check("R5 dst", 32'(sb_state), 32'(saved));
      complete(12); cyc();
      check("R5 cmpl", 32'(sb_state), 32'(saved));
      // R7: one source pending
      dispatch(0, 7, 1, 1, 6, 0, 0, 0); cyc();
      check("R7 partial", 32'(ent_ready[0]), 0);
      complete(6); cyc();
      check("R7 both", 32'(ent_ready[0]), 1);
      // R8: same-cycle completion at dispatch
      dispatch(1, 8, 7, 0, 0, 1, 0, 0); complete(7); cyc();
      check("R8", 32'(ent_ready[1]), 1);
      // R11: overwrite occupied slot with a pending source
      dispatch(1, 9, 2, 0, 0, 1, 0, 0); cyc();
      check("R11", 32'(ent_ready[1]), 0);
      // R9: squash at 7 removes seq 9 only
      squash(7); cyc();
      check("R9 survivors", 32'(ent_valid), 32'b1101);
      complete(2); cyc();
      check("R9 no revive", 32'(ent_ready[1]), 0);
      // R10: younger dispatch in squash cycle dropped, older accepted
      squash(4); dispatch(1, 10, 0, 1, 0, 1, 0, 0); cyc();
      check("R10 drop", 32'(ent_valid), 32'b1100);
      squash(4); dispatch(1, 2, 0, 1, 0, 1, 0, 0); cyc();
      check("R10 accept", 32'(ent_ready[1]), 1);

      // sweep: every tag against every ready-source combination
      for (int t = 0; t < 12; t++) begin
         for (int m = 0; m < 8; m++) begin
            bit fr, sbset, same;
            string lbl;
            fr = m[0]; sbset = m[1]; same = m[2];
            if (sbset) complete(t);
            else dispatch(3, 0, 0, 1, 0, 1, 1, t);
            cyc();
            dispatch(0, 0, t, fr, 0, 1, 0, 0);
            if (same) complete(t);
            cyc();
            if (t >= NP) lbl = "R5 sweep";
            else if (fr) lbl = "R2 sweep";
            else if (same) lbl = "R8 sweep";
            else lbl = "R3 sweep";
            check(lbl, 32'(ent_ready[0]), 32'(fr || t >= NP || sbset || same));
         end
      end

      // random traffic against the model
      for (int i = 0; i < 1500; i++) begin
         if ($urandom_range(1, 0) == 1)
            dispatch(int'($urandom_range(3, 0)), int'($urandom_range(31, 0)),
                     int'($urandom_range(11, 0)), ($urandom_range(3, 0) == 0),
                     int'($urandom_range(11, 0)), ($urandom_range(3, 0) == 0),
                     ($urandom_range(1, 0) == 1), int'($urandom_range(11, 0)));
         if ($urandom_range(1, 0) == 1) complete(int'($urandom_range(11, 0)));
         if ($urandom_range(9, 0) == 0) squash(int'($urandom_range(31, 0)));
         cyc();
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end
endmodule